// File: doc/BRIEF.md
# Floating-Point Register Box, Unbox and Sign-Injection Unit

This purely combinational unit sits between a 128-bit floating-point register file and narrower floating-point datapaths. On the write side it takes a result in half, single or double precision. It keeps the significant low bits and fills every bit above them, up to bit 127, with ones. A quad-precision value passes through unchanged.

On the read side it examines each of two register operands. It decides whether the operand carries a valid box for the selected precision and returns the unpacked value, zero-extended. When the box is broken, it returns the canonical NaN of that precision. Validity is nested: a narrow box counts only when every wider box around it is intact as well. A broken box never traps.

The same operands feed a sign-injection stage with four operations: copy the sign of B, copy the inverted sign of B, XOR the two signs, and negate A. The result is boxed again for write-back. A small resolver turns the instruction's rounding-mode field into an effective mode. The field value 7 picks the dynamic mode. It flags an illegal instruction when the effective mode is out of range. Floating-point arithmetic and the register storage are handled elsewhere.

Top module: `fpbox_top`

## Requirements
- R1: For `prec_sel` 0 (half, 16 bits), 1 (single, 32 bits) and 2 (double, 64 bits), `wr_boxed` holds the low width bits of `wr_val` with every bit above them set to one. For `prec_sel` 3 (quad, 128 bits), `wr_boxed` equals `wr_val`.
- R2: In double precision, an operand's `*_ok` is 1 exactly when bits 127:64 of the operand are all ones.
- R3: In single precision, `*_ok` is 1 only when the double box is valid and bits 63:32 are all ones. This is equivalent to bits 127:32 being all ones.
- R4: In half precision, `*_ok` is 1 only when the single box is valid and bits 31:16 are all ones. This is equivalent to bits 127:16 being all ones.
- R5: When `*_ok` is 1, `*_val` is the low width bits of the operand with zeros above. In quad precision `*_ok` is always 1 and `*_val` is the whole operand.
- R6: When `*_ok` is 0, `*_val` is the canonical NaN of the precision, zero-extended: 0x7E00 for half, 0x7FC00000 for single, 0x7FF8000000000000 for double.
- R7: With `sgn_op` 0, `sgn_res` keeps every magnitude bit of the unpacked A and takes the sign of the unpacked B. The sign is bit width-1, and bit 127 in quad. The result is boxed as in R1.
- R8: With `sgn_op` 1, the result sign is the inverse of the unpacked B's sign. Everything else is as in R7.
- R9: With `sgn_op` 2, the result sign is the XOR of the unpacked A and B signs. Everything else is as in R7.
- R10: With `sgn_op` 3, the result is the unpacked A with its sign inverted, boxed as in R1. B has no effect on it.
- R11: In quad precision, every sign-injection operation leaves bits 126:0 of `rd_a` unchanged in `sgn_res`.
- R12: `rm_eff` equals `rm_dyn` when `rm_field` is 7 and equals `rm_field` otherwise. The encodings are 0 nearest-even, 1 toward zero, 2 down, 3 up, 4 nearest with ties to maximum magnitude.
- R13: `rm_illegal` is 1 exactly when `rm_eff` is greater than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prec_sel | input | 2 | Precision: 0 half, 1 single, 2 double, 3 quad |
| sgn_op | input | 2 | Sign operation: 0 copy, 1 inverted copy, 2 XOR, 3 negate A |
| wr_val | input | 128 | Result to be boxed for the register file |
| wr_boxed | output | 128 | Boxed write value |
| rd_a | input | 128 | Register operand A |
| rd_b | input | 128 | Register operand B |
| a_val | output | 128 | Unpacked operand A, zero-extended |
| a_ok | output | 1 | Box of A valid for the precision |
| b_val | output | 128 | Unpacked operand B, zero-extended |
| b_ok | output | 1 | Box of B valid for the precision |
| sgn_res | output | 128 | Boxed sign-injection result |
| rm_field | input | 3 | Rounding-mode field of the instruction |
| rm_dyn | input | 3 | Dynamic rounding mode from the control register |
| rm_eff | output | 3 | Effective rounding mode |
| rm_illegal | output | 1 | Effective mode out of range |

## Verification
The immediate assertions inside the unit take for granted that every input bit holds a defined 0 or 1. They also take for granted that the 2-bit precision and operation codes are always fully driven, since all four values of each code are legal. The bench honours this by driving every input on every vector from an LFSR or from fixed patterns. It changes the inputs only away from the point where it samples. Operands are shaped so that boxes are intact at each of the three depths, broken at a random bit above the payload, or entirely random. This keeps both sides of each nested validity test and the NaN substitution in play for every precision and operation.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;

    // Register word width and number of boxed (narrower) formats
    localparam int REG_W  = 128;
    localparam int NARROW = 3;

    typedef enum logic [1:0] {
        PREC_H = 2'd0,
        PREC_S = 2'd1,
        PREC_D = 2'd2,
        PREC_Q = 2'd3
    } prec_e;

    typedef enum logic [1:0] {
        SGN_COPY   = 2'd0,
        SGN_INV    = 2'd1,
        SGN_XOR    = 2'd2,
        SGN_NEGATE = 2'd3
    } sgn_op_e;

    localparam logic [2:0] RM_SEL_DYN   = 3'd7;
    localparam logic [2:0] RM_MAX_LEGAL = 3'd4;

    // Payload width of narrow format idx: 16, 32, 64
    function automatic int fmt_width(input int idx);
        return 16 << idx;
    endfunction

    // Canonical quiet NaN of narrow format idx
    function automatic logic [63:0] canon_nan(input int idx);
        case (idx)
            0:       return 64'h0000_0000_0000_7E00;
            1:       return 64'h0000_0000_7FC0_0000;
            default: return 64'h7FF8_0000_0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/fpbox_valid.sv
module fpbox_valid
    import fpbox_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0]      opnd,
    output logic [NARROW-1:0] box_ok
);
    // Each box is tested against its full upper span independently,
    // so nesting of the results is a property, not a wiring artefact.
    for (genvar g = 0; g < NARROW; g++) begin : g_box
        localparam int FW = fmt_width(g);
        assign box_ok[g] = &opnd[W-1:FW];
    end
endmodule

// File: rtl/fpbox_unpack.sv
module fpbox_unpack
    import fpbox_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0]      opnd,
    input  prec_e             prec,
    input  logic [NARROW-1:0] box_ok,
    output logic [W-1:0]      val,
    output logic              ok
);
    logic [W-1:0] cand [NARROW];

    for (genvar g = 0; g < NARROW; g++) begin : g_cand
        localparam int FW = fmt_width(g);
        localparam logic [63:0] NAN_PAT = canon_nan(g);
        assign cand[g] = box_ok[g] ? {{(W-FW){1'b0}}, opnd[FW-1:0]}
                                   : {{(W-64){1'b0}}, NAN_PAT};
    end

    always_comb begin
        unique case (prec)
            PREC_H: begin val = cand[0]; ok = box_ok[0]; end
            PREC_S: begin val = cand[1]; ok = box_ok[1]; end
            PREC_D: begin val = cand[2]; ok = box_ok[2]; end
            default: begin val = opnd;   ok = 1'b1;      end
        endcase
    end
endmodule

// File: rtl/fpbox_pack.sv
module fpbox_pack
    import fpbox_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] raw,
    input  prec_e        prec,
    output logic [W-1:0] boxed
);
    logic [W-1:0] cand [NARROW];

    for (genvar g = 0; g < NARROW; g++) begin : g_cand
        localparam int FW = fmt_width(g);
        assign cand[g] = {{(W-FW){1'b1}}, raw[FW-1:0]};
    end

    always_comb begin
        unique case (prec)
            PREC_H:  boxed = cand[0];
            PREC_S:  boxed = cand[1];
            PREC_D:  boxed = cand[2];
            default: boxed = raw;
        endcase
    end
endmodule

// File: rtl/fpbox_sgnj.sv
module fpbox_sgnj
    import fpbox_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  prec_e        prec,
    input  sgn_op_e      op,
    output logic [W-1:0] res
);
    localparam int SPW = $clog2(W);

    logic [SPW-1:0] spos;
    logic           sa;
    logic           sb;
    logic           snew;

    always_comb begin
        unique case (prec)
            PREC_H:  spos = SPW'(fmt_width(0) - 1);
            PREC_S:  spos = SPW'(fmt_width(1) - 1);
            PREC_D:  spos = SPW'(fmt_width(2) - 1);
            default: spos = SPW'(W - 1);
        endcase
        sa = a[spos];
        sb = b[spos];
        unique case (op)
            SGN_COPY:   snew = sb;
            SGN_INV:    snew = ~sb;
            SGN_XOR:    snew = sa ^ sb;
            default:    snew = ~sa;
        endcase
        res       = a;
        res[spos] = snew;
    end
endmodule

// File: rtl/fpbox_rm.sv
module fpbox_rm
    import fpbox_pkg::*;
(
    input  logic [2:0] field,
    input  logic [2:0] dyn,
    output logic [2:0] mode,
    output logic       illegal
);
    always_comb begin
        mode    = (field == RM_SEL_DYN) ? dyn : field;
        illegal = (mode > RM_MAX_LEGAL);
    end
endmodule

// File: rtl/fpbox_top.sv
module fpbox_top
    import fpbox_pkg::*;
(
    input  logic [1:0]   prec_sel,
    input  logic [1:0]   sgn_op,
    input  logic [127:0] wr_val,
    output logic [127:0] wr_boxed,
    input  logic [127:0] rd_a,
    input  logic [127:0] rd_b,
    output logic [127:0] a_val,
    output logic         a_ok,
    output logic [127:0] b_val,
    output logic         b_ok,
    output logic [127:0] sgn_res,
    input  logic [2:0]   rm_field,
    input  logic [2:0]   rm_dyn,
    output logic [2:0]   rm_eff,
    output logic         rm_illegal
);
    prec_e             prec;
    sgn_op_e           op;
    logic [NARROW-1:0] a_box;
    logic [NARROW-1:0] b_box;
    logic [REG_W-1:0]  sgn_raw;

    assign prec = prec_e'(prec_sel);
    assign op   = sgn_op_e'(sgn_op);

    fpbox_pack #(.W(REG_W)) u_pack_wr (
        .raw(wr_val), .prec(prec), .boxed(wr_boxed)
    );

    fpbox_valid #(.W(REG_W)) u_valid_a (.opnd(rd_a), .box_ok(a_box));
    fpbox_valid #(.W(REG_W)) u_valid_b (.opnd(rd_b), .box_ok(b_box));

    fpbox_unpack #(.W(REG_W)) u_unpack_a (
        .opnd(rd_a), .prec(prec), .box_ok(a_box), .val(a_val), .ok(a_ok)
    );
    fpbox_unpack #(.W(REG_W)) u_unpack_b (
        .opnd(rd_b), .prec(prec), .box_ok(b_box), .val(b_val), .ok(b_ok)
    );

    fpbox_sgnj #(.W(REG_W)) u_sgnj (
        .a(a_val), .b(b_val), .prec(prec), .op(op), .res(sgn_raw)
    );

    fpbox_pack #(.W(REG_W)) u_pack_sgn (
        .raw(sgn_raw), .prec(prec), .boxed(sgn_res)
    );

    fpbox_rm u_rm (
        .field(rm_field), .dyn(rm_dyn), .mode(rm_eff), .illegal(rm_illegal)
    );

    // Checks across the separately built pieces
    logic [REG_W-1:0] chk_mag_mask;
    logic [REG_W-1:0] chk_nan;
    always_comb begin
        unique case (prec)
            PREC_H:  begin chk_mag_mask = {{113{1'b0}}, {15{1'b1}}};
                           chk_nan = {64'd0, canon_nan(0)}; end
            PREC_S:  begin chk_mag_mask = {{97{1'b0}}, {31{1'b1}}};
                           chk_nan = {64'd0, canon_nan(1)}; end
            PREC_D:  begin chk_mag_mask = {{65{1'b0}}, {63{1'b1}}};
                           chk_nan = {64'd0, canon_nan(2)}; end
            default: begin chk_mag_mask = {1'b0, {127{1'b1}}};
                           chk_nan = '0; end
        endcase

        AST_BOX_NESTED: assert (!(a_box[0] && !a_box[1]) && !(a_box[1] && !a_box[2]))
            else $error("narrow box valid while a wider box is broken"); // R4
        AST_NAN_ON_BAD: assert (a_ok || (a_val == chk_nan))
            else $error("broken box did not yield the canonical NaN"); // R6
        AST_SGN_MAG: assert ((sgn_res & chk_mag_mask) == (a_val & chk_mag_mask))
            else $error("sign injection altered magnitude bits"); // R7
        AST_QUAD_LOW: assert ((prec != PREC_Q) || (sgn_res[126:0] == rd_a[126:0]))
            else $error("quad sign injection touched bits below 127"); // R11
        AST_RM_RANGE: assert (rm_illegal || (rm_eff <= RM_MAX_LEGAL))
            else $error("out-of-range rounding mode not flagged"); // R13
    end
endmodule

// File: tb/fpbox_top_bench.sv
module fpbox_top_bench;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   prec_sel = '0;
    logic [1:0]   sgn_op = '0;
    logic [127:0] wr_val = '0;
    logic [127:0] wr_boxed;
    logic [127:0] rd_a = '0;
    logic [127:0] rd_b = '0;
    logic [127:0] a_val;
    logic         a_ok;
    logic [127:0] b_val;
    logic         b_ok;
    logic [127:0] sgn_res;
    logic [2:0]   rm_field = '0;
    logic [2:0]   rm_dyn = '0;
    logic [2:0]   rm_eff;
    logic         rm_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

    always #(CLK_P/2) clk = ~clk;

    fpbox_top u_fpbox_top (
        .prec_sel(prec_sel), .sgn_op(sgn_op), .wr_val(wr_val), .wr_boxed(wr_boxed),
        .rd_a(rd_a), .rd_b(rd_b), .a_val(a_val), .a_ok(a_ok), .b_val(b_val),
        .b_ok(b_ok), .sgn_res(sgn_res), .rm_field(rm_field), .rm_dyn(rm_dyn),
        .rm_eff(rm_eff), .rm_illegal(rm_illegal)
    );

    function automatic logic [63:0] step(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    function automatic logic [127:0] m_canon(input int p);
        case (p)
            0: return 128'h7E00;
            1: return 128'h7FC0_0000;
            default: return 128'h7FF8_0000_0000_0000;
        endcase
    endfunction

    function automatic logic [127:0] m_mask(input int p);
        return (p == 3) ? {128{1'b1}} : ((128'd1 << (16 << p)) - 128'd1);
    endfunction

    function automatic bit m_ok(input logic [127:0] v, input int p);
        if (p == 3) return 1'b1;
        return ((v | m_mask(p)) == {128{1'b1}});
    endfunction

    function automatic logic [127:0] m_unbox(input logic [127:0] v, input int p);
        if (p == 3) return v;
        return m_ok(v, p) ? (v & m_mask(p)) : m_canon(p);
    endfunction

    function automatic logic [127:0] m_box(input logic [127:0] v, input int p);
        if (p == 3) return v;
        return (v & m_mask(p)) | ~m_mask(p);
    endfunction

    function automatic logic [127:0] m_sgnj(input logic [127:0] a, input logic [127:0] b,
                                           input int op, input int p);
        logic [127:0] ua = m_unbox(a, p);
        logic [127:0] ub = m_unbox(b, p);
        int sp = (p == 3) ? 127 : ((16 << p) - 1);
        logic ns;
        case (op)
            0: ns = ub[sp];
            1: ns = ~ub[sp];
            2: ns = ua[sp] ^ ub[sp];
            default: ns = ~ua[sp];
        endcase
        ua[sp] = ns;
        return m_box(ua, p);
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] shape(input logic [127:0] v, input int mode, input int pos);
        logic [127:0] r = v;
        case (mode)
            0: r = v;
            1: r = v | ~m_mask(0);
            2: r = v | ~m_mask(1);
            3: r = v | ~m_mask(2);
            default: begin r = v | ~m_mask(0); r[pos] = 1'b0; end
        endcase
        return r;
    endfunction

    function automatic string ok_tag(input int p);
        case (p)
            0: return "R4";
            1: return "R3";
            2: return "R2";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Zero inputs, half precision: A and B boxes broken
        check("R6 idle a_val", a_val, 128'h7E00);
        check("R4 idle a_ok", {127'd0, a_ok}, 128'd0);
        check("R1 idle wr_boxed", wr_boxed, {{112{1'b1}}, 16'h0});

        // Directed nesting cases
        @(posedge clk);
        prec_sel = 2'd1; rd_a = {64'd0, 32'hFFFF_FFFF, 32'h3F80_0000};
        @(negedge clk);
        check("R3 wider box broken", {127'd0, a_ok}, 128'd0);
        @(posedge clk);
        prec_sel = 2'd0; rd_a = {{64{1'b1}}, 32'h0000_FFFF, 32'hFFFF_3C00};
        @(negedge clk);
        check("R4 single box broken", {127'd0, a_ok}, 128'd0);
        check("R6 half NaN", a_val, 128'h7E00);
        @(posedge clk);
        prec_sel = 2'd2; rd_a = {{64{1'b1}}, 64'h4000_0000_0000_0000};
        @(negedge clk);
        check("R2 double ok", {127'd0, a_ok}, 128'd1);

        // Sweep: precision x operation x operand shapes
        for (int p = 0; p < 4; p++) begin
            for (int op = 0; op < 4; op++) begin
                for (int k = 0; k < 40; k++) begin
                    logic [127:0] ra, rb, wv;
                    logic [127:0] ea, eb;
                    string sg;
                    int ma, mb;
                    lfsr = step(lfsr); ra[63:0] = lfsr;
                    lfsr = step(lfsr); ra[127:64] = lfsr;
                    lfsr = step(lfsr); rb[63:0] = lfsr;
                    lfsr = step(lfsr); rb[127:64] = lfsr;
                    lfsr = step(lfsr); wv = {lfsr, ~lfsr};
                    ma = k % 5;
                    mb = (k / 5) % 5;
                    lfsr = step(lfsr);
                    ra = shape(ra, ma, 16 + int'(lfsr[6:0] % 112));
                    rb = shape(rb, mb, 16 + int'(lfsr[14:8] % 112));
                    @(posedge clk);
                    prec_sel = 2'(p); sgn_op = 2'(op);
                    rd_a = ra; rd_b = rb; wr_val = wv;
                    @(negedge clk);
                    ea = m_unbox(ra, p);
                    eb = m_unbox(rb, p);
                    check("R1 write box", wr_boxed, m_box(wv, p));
                    check(ok_tag(p), {127'd0, a_ok}, {127'd0, m_ok(ra, p)});
                    check(ok_tag(p), {127'd0, b_ok}, {127'd0, m_ok(rb, p)});
                    check(m_ok(ra, p) ? "R5 a_val" : "R6 a_val", a_val, ea);
                    check(m_ok(rb, p) ? "R5 b_val" : "R6 b_val", b_val, eb);
                    case (op)
                        0: sg = "R7 copy";
                        1: sg = "R8 inverted";
                        2: sg = "R9 xor";
                        default: sg = "R10 negate";
                    endcase
                    if (p == 3) sg = {sg, " R11 quad"};
                    check(sg, sgn_res, m_sgnj(ra, rb, op, p));
                end
            end
        end

        // Rounding-mode resolution sweep
        for (int f = 0; f < 8; f++) begin
            for (int d = 0; d < 8; d++) begin
                int e;
                @(posedge clk);
                rm_field = 3'(f); rm_dyn = 3'(d);
                @(negedge clk);
                e = (f == 7) ? d : f;
                check("R12 rm_eff", {125'd0, rm_eff}, 128'(e));
                check("R13 rm_illegal", {127'd0, rm_illegal}, {127'd0, (e > 4)});
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule